// File: doc/BRIEF.md
# EEPROM Status Register and Write-Protect Unit

This block sits between the serial front end of a small serial EEPROM and its storage array. It keeps the status byte: the write enable latch, the busy flag, two block-protect bits and the enable bit for the hardware protect pin. The front end hands it each completed byte of a selected frame, a pulse when chip select returns high, a flag that says whether a byte was left unfinished, and the start address of a write. From these inputs the block decides whether the frame becomes an internal write.

When chip select rises, the unit looks at the opcode of the frame, the number of bytes, the latch and the protection state. It then issues a one-cycle grant for an array write or for a status write, or it issues no grant. The busy flag stays set until the array timer reports that the write is done. At that point the busy flag and the write enable latch both clear. The status byte is always available, so a read-status command can return it at any time, including during a write.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset the status byte is 0x00. Its layout is bit 7 = protect-pin enable, bits 3..2 = block-protect code, bit 1 = write enable latch, bit 0 = busy flag, and bits 6..4 always read 0.
- R2: A frame made of exactly the single byte 0x06, closed with no partial byte, sets the write enable latch in the cycle after the deselect pulse.
- R3: A frame made of exactly the single byte 0x04, closed with no partial byte, clears the write enable latch.
- R4: A frame with opcode 0x02, at least four whole bytes (opcode, two address bytes, data) and no partial byte gives a one-cycle `arr_grant` in the cycle after deselect. This happens only when the latch is 1, the busy flag is 0 and the start address is not protected.
- R5: Block-protect code 00 protects no address, 01 protects the top quarter of the address space, 10 protects the top half and 11 protects every address.
- R6: A frame with opcode 0x01, at least two whole bytes and no partial byte gives a one-cycle `sts_grant` only when the latch is 1, the busy flag is 0, and the hardware protect is inactive. Hardware protect is active when `wp_n` is low and the enable bit is 1. On a grant, bit 7 and bits 3..2 of the second byte are loaded, and its other bits are ignored.
- R7: Every grant sets the busy flag. A `wr_done` pulse while busy clears both the busy flag and the latch. A `wr_done` pulse while idle has no effect.
- R8: While the busy flag is 1, every frame is ignored, including 0x06 and 0x04.
- R9: An opcode 0x06 frame that carries more bytes, or that ends with a partial byte, leaves the latch unchanged. The same holds for write frames that are too short or that end with a partial byte.
- R10: Hardware protect never blocks array writes, and `wp_n` is ignored while the protect-pin enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | One-cycle pulse: a whole byte of the frame was received |
| byte_val | input | 8 | Value of the received byte |
| partial_bits | input | 1 | With `desel`: the frame ended inside a byte |
| desel | input | 1 | One-cycle pulse: chip select returned high |
| wr_addr | input | AW | Start address of the array write |
| wp_n | input | 1 | Hardware protect pin, low means protect |
| wr_done | input | 1 | One-cycle pulse: internal write finished |
| arr_grant | output | 1 | One-cycle grant for an array write |
| sts_grant | output | 1 | One-cycle grant for a status write |
| status | output | 8 | Current status byte |

## Verification
The assertions watch every cycle for these properties: the unused status bits stay zero, the two grants never coincide, every grant raises the busy flag, and a grant never appears unless the latch was set and the unit was idle. They also check that no status grant appears under active hardware protect and that no array grant appears under full block protection. Frame framing rules cannot be shown by single-cycle properties. These include the latch ignoring a 0x06 opcode followed by more bytes, frames being ignored while busy, and the quarter and half address boundaries. The bench scenarios cover them, with a reference model tracking the status byte across directed and random frames.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } sr_opcode_e;

  localparam int ST_WPEN  = 7;
  localparam int ST_BP_HI = 3;
  localparam int ST_BP_LO = 2;
  localparam int ST_WEL   = 1;
  localparam int ST_WIP   = 0;

  typedef struct packed {
    logic wren;
    logic wrdi;
    logic arr_ok;
    logic sts_ok;
  } sr_event_t;

endpackage

// File: rtl/sr_frame_tracker.sv
module sr_frame_tracker #(
  parameter int ADDR_BYTES = 2,
  parameter int CW         = $clog2(ADDR_BYTES + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic [7:0]    byte_val,
  input  logic          desel,
  output logic [7:0]    op_q,
  output logic [2:0]    arg_q,
  output logic [CW-1:0] cnt_q
);

  localparam int CNT_MAX = ADDR_BYTES + 2;

  logic [7:0]    op_d;
  logic [2:0]    arg_d;
  logic [CW-1:0] cnt_d;
  logic          op_en, arg_en, cnt_en;

  always_comb begin
    op_d   = byte_val;
    arg_d  = {byte_val[7], byte_val[3:2]};
    op_en  = byte_stb && !desel && (cnt_q == '0);
    arg_en = byte_stb && !desel && (cnt_q == CW'(1));
    cnt_en = desel || (byte_stb && (cnt_q != CW'(CNT_MAX)));
    cnt_d  = desel ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      arg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (op_en)  op_q  <= op_d;
      if (arg_en) arg_q <= arg_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sr_protect_decode.sv
module sr_protect_decode #(
  parameter int AW = 11
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  input  logic          wpen,
  input  logic          wp_n,
  output logic          blk_prot,
  output logic          sts_locked
);

  always_comb begin
    unique case (bp)
      2'b00:   blk_prot = 1'b0;
      2'b01:   blk_prot = (addr[AW-1:AW-2] == 2'b11);
      2'b10:   blk_prot = addr[AW-1];
      default: blk_prot = 1'b1;
    endcase
    sts_locked = wpen && !wp_n;
  end

endmodule

// File: rtl/sr_status_reg.sv
module sr_status_reg
  import sr_wp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sr_event_t ev,
  input  logic [2:0] sr_new,
  input  logic      wr_done,
  output logic [7:0] status
);

  logic       wpen_q, wel_q, wip_q;
  logic [1:0] bp_q;
  logic       wpen_d, wel_d, wip_d;
  logic [1:0] bp_d;
  logic       nv_en, wel_en, wip_en;

  always_comb begin
    wpen_d = sr_new[2];
    bp_d   = sr_new[1:0];
    nv_en  = !wip_q && ev.sts_ok;
    wel_en = 1'b0;
    wel_d  = wel_q;
    wip_en = 1'b0;
    wip_d  = wip_q;
    if (wip_q) begin
      if (wr_done) begin
        wip_en = 1'b1;
        wip_d  = 1'b0;
        wel_en = 1'b1;
        wel_d  = 1'b0;
      end
    end else begin
      if (ev.wren) begin
        wel_en = 1'b1;
        wel_d  = 1'b1;
      end else if (ev.wrdi) begin
        wel_en = 1'b1;
        wel_d  = 1'b0;
      end
      if (ev.arr_ok || ev.sts_ok) begin
        wip_en = 1'b1;
        wip_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
    end else begin
      if (nv_en) begin
        wpen_q <= wpen_d;
        bp_q   <= bp_d;
      end
      if (wel_en) wel_q <= wel_d;
      if (wip_en) wip_q <= wip_d;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_WPEN]  = wpen_q;
    status[ST_BP_HI] = bp_q[1];
    status[ST_BP_LO] = bp_q[0];
    status[ST_WEL]   = wel_q;
    status[ST_WIP]   = wip_q;
  end

endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
  import sr_wp_pkg::*;
#(
  parameter int AW         = 11,
  parameter int ADDR_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic [7:0]    byte_val,
  input  logic          partial_bits,
  input  logic          desel,
  input  logic [AW-1:0] wr_addr,
  input  logic          wp_n,
  input  logic          wr_done,
  output logic          arr_grant,
  output logic          sts_grant,
  output logic [7:0]    status
);

  localparam int CW        = $clog2(ADDR_BYTES + 3);
  localparam int WR_MIN    = ADDR_BYTES + 2;
  localparam int WRSR_MIN  = 2;

  logic          rst_meta_n, rst_sync_n;
  logic [7:0]    op_q;
  logic [2:0]    arg_q;
  logic [CW-1:0] cnt_q;
  logic          blk_prot, sts_locked, frame_end;
  sr_event_t     ev;
  logic          arr_grant_q, sts_grant_q;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sr_frame_tracker #(.ADDR_BYTES(ADDR_BYTES), .CW(CW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .desel    (desel),
    .op_q     (op_q),
    .arg_q    (arg_q),
    .cnt_q    (cnt_q)
  );

  sr_protect_decode #(.AW(AW)) u_prot (
    .bp         (status[ST_BP_HI:ST_BP_LO]),
    .addr       (wr_addr),
    .wpen       (status[ST_WPEN]),
    .wp_n       (wp_n),
    .blk_prot   (blk_prot),
    .sts_locked (sts_locked)
  );

  always_comb begin
    frame_end = desel && !partial_bits && !status[ST_WIP];
    ev.wren   = frame_end && (op_q == OP_WREN) && (cnt_q == CW'(1));
    ev.wrdi   = frame_end && (op_q == OP_WRDI) && (cnt_q == CW'(1));
    ev.arr_ok = frame_end && (op_q == OP_WRITE) && (cnt_q >= CW'(WR_MIN))
                && status[ST_WEL] && !blk_prot;
    ev.sts_ok = frame_end && (op_q == OP_WRSR) && (cnt_q >= CW'(WRSR_MIN))
                && status[ST_WEL] && !sts_locked;
  end

  sr_status_reg u_sreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ev      (ev),
    .sr_new  (arg_q),
    .wr_done (wr_done),
    .status  (status)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      arr_grant_q <= 1'b0;
      sts_grant_q <= 1'b0;
    end else begin
      arr_grant_q <= ev.arr_ok;
      sts_grant_q <= ev.sts_ok;
    end
  end

  assign arr_grant = arr_grant_q;
  assign sts_grant = sts_grant_q;

endmodule

// File: rtl/sr_wp_checker.sv
module sr_wp_checker
  import sr_wp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       arr_grant,
  input logic       sts_grant,
  input logic [7:0] status
);

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  a_r4_grants_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_grant && sts_grant));

  a_r7_grant_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_grant || sts_grant) |-> status[ST_WIP]);

  a_r4_grant_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_grant || sts_grant) |-> ($past(status[ST_WEL]) && !$past(status[ST_WIP])));

  a_r6_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
    sts_grant |-> !($past(status[ST_WPEN]) && !$past(wp_n)));

  a_r5_full_protect: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> ($past(status[ST_BP_HI:ST_BP_LO]) != 2'b11));

  a_r7_done_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_WIP]) |-> !status[ST_WEL]);

endmodule

bind sr_wp_unit sr_wp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .arr_grant (arr_grant),
  .sts_grant (sts_grant),
  .status    (status)
);

// File: tb/sr_wp_unit_tb.sv
module sr_wp_unit_tb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          byte_stb, partial_bits, desel, wp_n, wr_done;
  logic [7:0]    byte_val;
  logic [AW-1:0] wr_addr;
  logic          arr_grant, sts_grant;
  logic [7:0]    status;

  int total = 0;
  int bad   = 0;
  logic       r_wpen, r_wel, r_wip;
  logic [1:0] r_bp;

  always #2 clk = ~clk;

  sr_wp_unit #(.AW(AW), .ADDR_BYTES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
    .partial_bits(partial_bits), .desel(desel), .wr_addr(wr_addr),
    .wp_n(wp_n), .wr_done(wr_done), .arr_grant(arr_grant),
    .sts_grant(sts_grant), .status(status)
  );

  function automatic bit is_prot(logic [1:0] bp, logic [AW-1:0] a);
    int sz = 1 << AW;
    case (bp)
      2'd0:    return 1'b0;
      2'd1:    return int'(a) >= (sz / 4) * 3;
      2'd2:    return int'(a) >= sz / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {r_wpen, 3'b000, r_bp, r_wel, r_wip};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(int nb, logic [7:0] op, logic [7:0] d1,
                       logic [AW-1:0] a, bit part, bit wp, string req);
    bit eg_a = 1'b0;
    bit eg_s = 1'b0;
    wr_addr = a;
    wp_n    = wp;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      byte_stb = 1'b1;
      byte_val = (i == 0) ? op : (i == 1) ? d1 : 8'(i * 37);
    end
    @(negedge clk);
    byte_stb     = 1'b0;
    desel        = 1'b1;
    partial_bits = part;
    if (!r_wip && !part) begin
      if (op == 8'h06 && nb == 1) r_wel = 1'b1;
      else if (op == 8'h04 && nb == 1) r_wel = 1'b0;
      else if (op == 8'h02 && nb >= 4 && r_wel && !is_prot(r_bp, a)) begin
        eg_a = 1'b1; r_wip = 1'b1;
      end else if (op == 8'h01 && nb >= 2 && r_wel && !(r_wpen && !wp)) begin
        eg_s = 1'b1; r_wip = 1'b1; r_wpen = d1[7]; r_bp = d1[3:2];
      end
    end
    @(negedge clk);
    desel        = 1'b0;
    partial_bits = 1'b0;
    chk({req, " arr_grant"}, 32'(arr_grant), 32'(eg_a));
    chk({req, " sts_grant"}, 32'(sts_grant), 32'(eg_s));
    chk({req, " status"},    32'(status),    32'(exp_status()));
  endtask

  task automatic done_pulse(string req);
    @(negedge clk);
    wr_done = 1'b1;
    if (r_wip) begin
      r_wip = 1'b0;
      r_wel = 1'b0;
    end
    @(negedge clk);
    wr_done = 1'b0;
    chk({req, " status after done"}, 32'(status), 32'(exp_status()));
  endtask

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_stb = 1'b0; byte_val = '0; partial_bits = 1'b0;
    desel = 1'b0; wr_addr = '0; wp_n = 1'b1; wr_done = 1'b0;
    r_wpen = 1'b0; r_wel = 1'b0; r_wip = 1'b0; r_bp = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 reset status", 32'(status), 32'h0);
    chk("R1 reset grants", 32'({arr_grant, sts_grant}), 32'h0);

    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b1, "R2 wren");
    frame(1, 8'h04, 8'h00, '0, 1'b0, 1'b1, "R3 wrdi");
    frame(2, 8'h06, 8'h02, '0, 1'b0, 1'b1, "R9 wren then more bytes");
    frame(1, 8'h06, 8'h00, '0, 1'b1, 1'b1, "R9 wren partial byte");
    frame(4, 8'h02, 8'h00, 11'h100, 1'b0, 1'b1, "R4 write no latch");
    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b1, "R2 wren again");
    frame(3, 8'h02, 8'h00, 11'h100, 1'b0, 1'b1, "R9 write too short");
    frame(4, 8'h02, 8'h00, 11'h100, 1'b1, 1'b1, "R9 write partial");
    frame(4, 8'h02, 8'h00, 11'h100, 1'b0, 1'b0, "R4 R10 write granted");
    frame(1, 8'h04, 8'h00, '0, 1'b0, 1'b1, "R8 wrdi while busy");
    frame(4, 8'h02, 8'h00, 11'h010, 1'b0, 1'b1, "R8 write while busy");
    done_pulse("R7 write done");
    done_pulse("R7 done while idle");
    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b1, "R2 wren");
    frame(2, 8'h01, 8'h7F, '0, 1'b0, 1'b0, "R10 R6 wrsr wpen clear ignores pin");
    done_pulse("R7 wrsr done");
    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b1, "R2 wren");
    frame(2, 8'h01, 8'h84, '0, 1'b0, 1'b1, "R6 wrsr sets enable and quarter");
    done_pulse("R7 wrsr done");
    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b0, "R2 wren under hw lock");
    frame(2, 8'h01, 8'h00, '0, 1'b0, 1'b0, "R6 wrsr blocked by pin");
    frame(4, 8'h02, 8'h00, 11'h600, 1'b0, 1'b0, "R5 quarter boundary protected");
    frame(4, 8'h02, 8'h00, 11'h5FF, 1'b0, 1'b0, "R5 R10 below quarter granted");
    done_pulse("R7 write done");
    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b1, "R2 wren");
    frame(2, 8'h01, 8'h8C, '0, 1'b0, 1'b1, "R6 wrsr full protect");
    done_pulse("R7 wrsr done");
    frame(1, 8'h06, 8'h00, '0, 1'b0, 1'b1, "R2 wren");
    frame(4, 8'h02, 8'h00, 11'h000, 1'b0, 1'b1, "R5 full protect address zero");

    void'($urandom(32'h1234_5EED));
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      int         pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: op = 8'h06;
        3:       op = 8'h04;
        4, 5:    op = 8'h02;
        6, 7:    op = 8'h01;
        8:       op = 8'h05;
        default: op = 8'($urandom);
      endcase
      frame((op == 8'h06 && $urandom_range(0, 3) != 0) ? 1 : $urandom_range(0, 5),
            op, 8'($urandom), AW'($urandom), ($urandom_range(0, 7) == 0),
            1'($urandom), "R4 R5 R6 R8 random frame");
      if ($urandom_range(0, 2) == 0) done_pulse("R7 random done");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule